// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects level-type interrupt requests from a small set of sources and routes them to several target contexts, two per hart when supervisor mode is configured. Each source carries a programmable priority. Each context has its own enable bits, priority threshold and claim/complete register, all reached through a simple 32-bit register port with a one-cycle registered response.

For every context the block continuously picks the best request that is pending, enabled there and not already claimed there. It raises that context's external-interrupt output when the winner's priority exceeds the context threshold. Software reads the claim register to take the winning ID, which marks it claimed in that context and drops its pending state. It writes the same ID back to signal completion, which makes the source eligible again. ID 0 stands for "no interrupt" throughout.

Top module: `irq_hub`

## Requirements
- R1: After reset all interrupt outputs and the response strobe are low, and every priority, enable word and threshold reads as zero.
- R2: A request is answered one clock later with `bus_rsp_o` high. Only aligned word accesses (`bus_size_i` = 2, address bits [1:0] = 0) are accepted. Any other request, and any request to an unmapped location, returns `bus_err_o` = 1 with read data 0, and a rejected write changes no state.
- R3: Address map (byte addresses): the priority of ID n is at 4*n, where ID 0 reads 0 and n above the source count is unmapped. Enable word w of context c is at 0x1000 + 0x80*c + 4*w, with bit b standing for ID 32*w + b. The threshold of context c is at 0x2000 + 0x100*c, and its claim/complete register is at 0x2004 + 0x100*c. Other offsets, context indexes at or above the context count, and addresses from 0x3000 upward are unmapped.
- R4: Bit 0 of enable word 0 always reads 0 whatever is written, and enable bits for IDs above the source count read 0.
- R5: Priority and threshold writes keep only the low 3 bits. The masked value is stored only if it is at most the maximum priority (6); otherwise the old value stays.
- R6: A source becomes pending on a rising edge of its level input. Pending clears on a falling edge or when the ID is claimed. A source still held high after its claim does not become pending again until it falls and rises.
- R7: A context considers only sources that are pending, enabled in it, not claimed in it, and of nonzero priority. The highest priority wins, and the lowest ID wins among equal priorities.
- R8: A context output is high exactly when its winner's priority is strictly greater than its threshold. The output follows a state change by one clock, and a source edge by two.
- R9: A claim read returns the context's winner ID, or 0 when there is none, regardless of the threshold. It marks that ID claimed in the context and clears its pending state for all contexts.
- R10: A completion write clears the claimed mark of the written ID only if the ID is at most the source count and is enabled in that context. Any other completion value has no effect.
- R11: With supervisor mode configured, context 2h drives `meip_o[h]` and context 2h+1 drives `seip_o[h]`. Without it, context h drives `meip_o[h]` and `seip_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level_i | input | NUM_SRC | Source request levels, bit k is ID k+1 |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rsp_o | output | 1 | Response strobe, one cycle after the request |
| bus_err_o | output | 1 | Access rejected |
| bus_rdata_o | output | 32 | Read data, zero on a rejected or write access |
| meip_o | output | NUM_HART | Machine external interrupt per hart |
| seip_o | output | NUM_HART | Supervisor external interrupt per hart |

## Verification
The hardest state to reach from the ports is a source that is pending but still claimed in a context whose enable for it was switched off in between. Completion must then be refused, and claims must keep returning 0 even though the request is live. The bench claims an ID and re-pulses its input so that it is pending again. It then clears the enable, writes the completion, restores the enable and claims once more. Only after a second completion with the enable set does the ID come back. A second hard case is a level held high through its own claim, which is reached by completing without ever lowering the input.

// File: rtl/irq_hub_pkg.sv
// Shared decode constants for the interrupt hub.
// Assumes a 16-bit byte address split into 4 KiB regions by bits [15:12].
package irq_hub_pkg;
    typedef enum logic [3:0] {
        RGN_PRIO = 4'h0,
        RGN_EN   = 4'h1,
        RGN_CTX  = 4'h2
    } region_e;

    localparam logic [1:0] SZ_WORD   = 2'd2;
    localparam logic [7:0] OFF_THR   = 8'h00;
    localparam logic [7:0] OFF_CLAIM = 8'h04;

    typedef struct packed {
        logic prio;
        logic en;
        logic thr;
        logic clm;
    } hit_t;
endpackage

// File: rtl/irq_hub_gateway.sv
// Edge gateway: turns each source level into a single pending flag.
// Assumes levels are already synchronous to clk; one event per source at a time.
module irq_hub_gateway #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] level_d;

    // Keep last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= level_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Rising edge sets pending; falling edge or claim clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)                          pend_o[g] <= 1'b0;
            else if (level_i[g] && !level_d[g])  pend_o[g] <= 1'b1;
            else if (!level_i[g] && level_d[g])  pend_o[g] <= 1'b0;
            else if (clr_i[g])                   pend_o[g] <= 1'b0;
        end

        AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[g]) |-> $past(level_i[g])); // R6
    end
endmodule

// File: rtl/irq_hub_select.sv
// Per-context winner selection over all candidate IDs.
// Assumes ID 0 is never a candidate; ties go to the lowest ID, priority 0 never wins.
module irq_hub_select #(
    parameter int NUM_IDS = 7,
    parameter int PRIO_W  = 3,
    localparam int IDW    = $clog2(NUM_IDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IDS-1:0]        cand_i,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
    output logic [IDW-1:0]            best_id_o,
    output logic [PRIO_W-1:0]         best_prio_o
);
    // Linear scan: a later ID replaces the current best only on strictly higher priority.
    always_comb begin
        best_id_o   = '0;
        best_prio_o = '0;
        for (int i = 1; i < NUM_IDS; i++) begin
            if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_prio_o)) begin
                best_id_o   = IDW'(i);
                best_prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    AST_WINNER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id_o != '0) |-> (cand_i[best_id_o] && best_prio_o != '0)); // R7
endmodule

// File: rtl/irq_hub.sv
// Interrupt hub top: register decode, per-context state, claim/complete and outputs.
// Assumes one register access per cycle at most; the response is registered.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC   = 6,
    parameter int NUM_HART  = 2,
    parameter bit HAS_SMODE = 1'b1,
    parameter int PRIO_W    = 3,
    parameter int MAX_PRIO  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_level_i,
    input  logic                bus_req_i,
    input  logic                bus_we_i,
    input  logic [1:0]          bus_size_i,
    input  logic [15:0]         bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic                bus_rsp_o,
    output logic                bus_err_o,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_HART-1:0] meip_o,
    output logic [NUM_HART-1:0] seip_o
);
    localparam int NUM_IDS  = NUM_SRC + 1;
    localparam int NUM_CTX  = HAS_SMODE ? 2 * NUM_HART : NUM_HART;
    localparam int EN_WORDS = (NUM_IDS + 31) / 32;
    localparam int IDW      = $clog2(NUM_IDS);
    localparam logic [9:0]        PID_MAX  = 10'(NUM_SRC);
    localparam logic [4:0]        EN_CTX_N = 5'(NUM_CTX);
    localparam logic [4:0]        EN_WD_N  = 5'(EN_WORDS);
    localparam logic [3:0]        CX_CTX_N = 4'(NUM_CTX);
    localparam logic [PRIO_W-1:0] MAXP     = PRIO_W'(MAX_PRIO);

    // Architectural state.
    logic [PRIO_W-1:0]  prio_q    [NUM_IDS];
    logic [NUM_IDS-1:0] en_q      [NUM_CTX];
    logic [NUM_IDS-1:0] claimed_q [NUM_CTX];
    logic [PRIO_W-1:0]  thr_q     [NUM_CTX];
    logic [NUM_CTX-1:0] irq_q;

    // Selection network signals.
    logic [NUM_SRC-1:0]        pend_src;
    logic [NUM_IDS-1:0]        pend_id;
    logic [NUM_IDS*PRIO_W-1:0] prio_flat;
    logic [NUM_IDS-1:0]        cand      [NUM_CTX];
    logic [IDW-1:0]            best_id   [NUM_CTX];
    logic [PRIO_W-1:0]         best_prio [NUM_CTX];
    logic [NUM_IDS-1:0]        claim_vec;

    // Address fields.
    region_e     region;
    logic [9:0]  prio_id;
    logic [4:0]  en_ctx;
    logic [4:0]  en_word;
    logic [3:0]  cx_ctx;
    logic [7:0]  cx_off;
    hit_t        hit;
    logic        acc_ok;
    logic        wr_ok;
    logic        rd_ok;
    logic [31:0] rd_nx;
    logic        claim_fire;

    assign region  = region_e'(bus_addr_i[15:12]);
    assign prio_id = bus_addr_i[11:2];
    assign en_ctx  = bus_addr_i[11:7];
    assign en_word = bus_addr_i[6:2];
    assign cx_ctx  = bus_addr_i[11:8];
    assign cx_off  = bus_addr_i[7:0];

    // Decode which register the access targets.
    always_comb begin
        hit.prio = (region == RGN_PRIO) && (prio_id <= PID_MAX);
        hit.en   = (region == RGN_EN) && (en_ctx < EN_CTX_N) && (en_word < EN_WD_N);
        hit.thr  = (region == RGN_CTX) && (cx_ctx < CX_CTX_N) && (cx_off == OFF_THR);
        hit.clm  = (region == RGN_CTX) && (cx_ctx < CX_CTX_N) && (cx_off == OFF_CLAIM);
    end

    assign acc_ok = (bus_size_i == SZ_WORD) && (bus_addr_i[1:0] == 2'b00) && (|hit);
    assign wr_ok  = bus_req_i && bus_we_i && acc_ok;
    assign rd_ok  = bus_req_i && !bus_we_i && acc_ok;

    // Gateway turns source levels into pending flags.
    irq_hub_gateway #(.NUM_SRC(NUM_SRC)) u_gateway (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (src_level_i),
        .clr_i   (claim_vec[NUM_IDS-1:1]),
        .pend_o  (pend_src)
    );
    assign pend_id = {pend_src, 1'b0};

    // Flatten priorities for the selectors.
    always_comb begin
        prio_flat = '0;
        for (int i = 0; i < NUM_IDS; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assign cand[c] = pend_id & en_q[c] & ~claimed_q[c];

        irq_hub_select #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_select (
            .clk         (clk),
            .rst_n       (rst_n),
            .cand_i      (cand[c]),
            .prio_i      (prio_flat),
            .best_id_o   (best_id[c]),
            .best_prio_o (best_prio[c])
        );

        // Register the context output from the winner and threshold.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[c] <= 1'b0;
            else        irq_q[c] <= best_prio[c] > thr_q[c];
        end

        AST_IRQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q[c] |-> $past(best_id[c] != '0)); // R8
        AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            thr_q[c] <= MAXP); // R5
        AST_ID0_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[c][0] && !claimed_q[c][0]); // R4
    end

    // Claim read: one-hot of the addressed context's winner.
    always_comb begin
        claim_vec  = '0;
        claim_fire = 1'b0;
        if (rd_ok && hit.clm) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                if (int'(cx_ctx) == c && best_id[c] != '0) begin
                    claim_fire = 1'b1;
                    for (int i = 1; i < NUM_IDS; i++)
                        if (best_id[c] == IDW'(i)) claim_vec[i] = 1'b1;
                end
            end
        end
    end

    // Read data mux for accepted reads.
    always_comb begin
        rd_nx = '0;
        if (hit.prio) begin
            for (int i = 1; i < NUM_IDS; i++)
                if (prio_id == 10'(i)) rd_nx = 32'(prio_q[i]);
        end else if (hit.en) begin
            for (int c = 0; c < NUM_CTX; c++)
                if (int'(en_ctx) == c)
                    for (int i = 0; i < NUM_IDS; i++)
                        if (int'(en_word) == i / 32) rd_nx[i % 32] = en_q[c][i];
        end else if (hit.thr) begin
            for (int c = 0; c < NUM_CTX; c++)
                if (int'(cx_ctx) == c) rd_nx = 32'(thr_q[c]);
        end else if (hit.clm) begin
            for (int c = 0; c < NUM_CTX; c++)
                if (int'(cx_ctx) == c) rd_nx = 32'(best_id[c]);
        end
    end

    // Priority registers: masked write, kept if above the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDS; i++) prio_q[i] <= '0;
        end else if (wr_ok && hit.prio) begin
            for (int i = 1; i < NUM_IDS; i++)
                if (prio_id == 10'(i) && bus_wdata_i[PRIO_W-1:0] <= MAXP)
                    prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
        end
    end

    // Per-context enables, thresholds and claimed marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]      <= '0;
                claimed_q[c] <= '0;
                thr_q[c]     <= '0;
            end
        end else begin
            for (int c = 0; c < NUM_CTX; c++) begin
                if (wr_ok && hit.en && int'(en_ctx) == c) begin
                    for (int i = 1; i < NUM_IDS; i++)
                        if (int'(en_word) == i / 32) en_q[c][i] <= bus_wdata_i[i % 32];
                end
                if (wr_ok && hit.thr && int'(cx_ctx) == c &&
                    bus_wdata_i[PRIO_W-1:0] <= MAXP)
                    thr_q[c] <= bus_wdata_i[PRIO_W-1:0];
                if (wr_ok && hit.clm && int'(cx_ctx) == c &&
                    bus_wdata_i < 32'(NUM_IDS)) begin
                    for (int i = 1; i < NUM_IDS; i++)
                        if (bus_wdata_i == 32'(i) && en_q[c][i]) claimed_q[c][i] <= 1'b0;
                end
                if (claim_fire && int'(cx_ctx) == c)
                    claimed_q[c] <= claimed_q[c] | claim_vec;
            end
        end
    end

    // Registered one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rsp_o   <= 1'b0;
            bus_err_o   <= 1'b0;
            bus_rdata_o <= '0;
        end else begin
            bus_rsp_o   <= bus_req_i;
            bus_err_o   <= bus_req_i && !acc_ok;
            bus_rdata_o <= rd_ok ? rd_nx : '0;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (bus_rsp_o && bus_rdata_o == '0)); // R2

    // Map contexts onto per-hart machine and supervisor outputs.
    for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
        if (HAS_SMODE) begin : g_two
            assign meip_o[h] = irq_q[2*h];
            assign seip_o[h] = irq_q[2*h+1];
        end else begin : g_one
            assign meip_o[h] = irq_q[h];
            assign seip_o[h] = 1'b0;
        end
    end
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd2;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rsp, err;
    logic [31:0] rdata;
    logic [1:0]  meip, seip;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_level_i(src),
        .bus_req_i(req), .bus_we_i(we), .bus_size_i(size),
        .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rsp_o(rsp), .bus_err_o(err), .bus_rdata_o(rdata),
        .meip_o(meip), .seip_o(seip)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic w, input logic [15:0] a, input logic [31:0] d,
                       input logic [1:0] sz, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; size = sz;
        @(negedge clk);
        rd = rdata; er = err;
        if (rsp !== 1'b1) begin
            n_total++; n_fail++;
            $display("FAIL R2: response strobe actual %0b expected 1", rsp);
        end
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er;
        bus(1'b1, a, d, 2'd2, rd, er);
    endtask

    task automatic rdw(input logic [15:0] a, output logic [31:0] d);
        logic er;
        bus(1'b0, a, 32'h0, 2'd2, d, er);
    endtask

    function automatic logic [15:0] a_prio(int id);  return 16'(4 * id);               endfunction
    function automatic logic [15:0] a_en(int c);     return 16'(32'h1000 + 32'h80 * c); endfunction
    function automatic logic [15:0] a_thr(int c);    return 16'(32'h2000 + 32'h100 * c); endfunction
    function automatic logic [15:0] a_clm(int c);    return 16'(32'h2004 + 32'h100 * c); endfunction

    task automatic claim_chk(input int c, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rdw(a_clm(c), d);
        chk(tag, d, exp);
    endtask

    task automatic clean();
        src = '0;
        tick(2);
        for (int c = 0; c < 4; c++) begin
            wr(a_en(c), 32'h7E);
            for (int i = 1; i <= 6; i++) wr(a_clm(c), 32'(i));
            wr(a_en(c), 32'h0);
            wr(a_thr(c), 32'h0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 meip", 32'(meip), 0);
        chk("R1 seip", 32'(seip), 0);
        chk("R1 rsp", 32'(rsp), 0);
        rdw(a_prio(3), d);  chk("R1 prio3", d, 0);
        rdw(a_thr(2), d);   chk("R1 thr2", d, 0);
        rdw(a_en(1), d);    chk("R1 en1", d, 0);
    endtask

    task automatic t_access();
        logic [31:0] d; logic e;
        wr(a_prio(1), 32'h2);
        bus(1'b0, a_prio(1), 0, 2'd1, d, e);
        chk("R2 half read err", 32'(e), 1);
        chk("R2 half read data", d, 0);
        bus(1'b1, a_prio(1), 32'h5, 2'd0, d, e);
        chk("R2 byte write err", 32'(e), 1);
        rdw(a_prio(1), d);  chk("R2 byte write no effect", d, 2);
        bus(1'b0, 16'h0006, 0, 2'd2, d, e);  chk("R2 misaligned err", 32'(e), 1);
        bus(1'b0, 16'h3000, 0, 2'd2, d, e);  chk("R3 region err", 32'(e), 1);
        bus(1'b0, a_en(4), 0, 2'd2, d, e);   chk("R3 ctx4 enable err", 32'(e), 1);
        bus(1'b0, a_prio(7), 0, 2'd2, d, e); chk("R3 id7 prio err", 32'(e), 1);
        bus(1'b0, 16'h2008, 0, 2'd2, d, e);  chk("R3 ctx offset err", 32'(e), 1);
        bus(1'b0, a_thr(3), 0, 2'd2, d, e);  chk("R3 ctx3 thr ok", 32'(e), 0);
        bus(1'b0, 16'h1004, 0, 2'd2, d, e);  chk("R3 enable word1 err", 32'(e), 1);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(a_en(0), 32'hFFFF_FFFF);
        rdw(a_en(0), d);  chk("R4 enable mask", d, 32'h7E);
        wr(a_en(0), 32'h0);
    endtask

    task automatic t_masking();
        logic [31:0] d;
        wr(a_thr(0), 32'h0B); rdw(a_thr(0), d); chk("R5 thr masked", d, 3);
        wr(a_thr(0), 32'h7);  rdw(a_thr(0), d); chk("R5 thr 7 kept old", d, 3);
        wr(a_thr(0), 32'hF);  rdw(a_thr(0), d); chk("R5 thr F kept old", d, 3);
        wr(a_prio(2), 32'h15); rdw(a_prio(2), d); chk("R5 prio masked", d, 5);
        wr(a_prio(2), 32'h7);  rdw(a_prio(2), d); chk("R5 prio 7 kept old", d, 5);
        wr(a_thr(0), 32'h0);
    endtask

    task automatic t_arbitrate();
        wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5); wr(a_prio(5), 1);
        wr(a_en(0), 32'h3E);
        src = 6'b00_1111;
        tick(2);
        chk("R8 meip raised", 32'(meip), 1);
        claim_chk(0, 2, "R7 tie lowest id");
        claim_chk(0, 3, "R9 claimed excluded");
        claim_chk(0, 1, "R7 prio0 skipped");
        claim_chk(0, 0, "R9 none left");
        tick(1);
        chk("R8 meip dropped", 32'(meip), 0);
        wr(a_clm(0), 2);
        claim_chk(0, 0, "R6 held level no repend");
        src[1] = 1'b0; tick(1); src[1] = 1'b1; tick(2);
        chk("R8 meip after repulse", 32'(meip), 1);
        claim_chk(0, 2, "R6 new edge pends");
    endtask

    task automatic t_threshold();
        clean();
        wr(a_en(0), 32'h3E);
        wr(a_thr(0), 5);
        src[2] = 1'b1; tick(2);
        chk("R8 equal thr masks", 32'(meip), 0);
        wr(a_thr(0), 4); tick(1);
        chk("R8 below thr raises", 32'(meip), 1);
        wr(a_thr(0), 6); tick(1);
        chk("R8 raised thr masks", 32'(meip), 0);
        claim_chk(0, 3, "R9 claim ignores thr");
    endtask

    task automatic t_complete();
        clean();
        wr(a_en(0), 32'h3E);
        src[2] = 1'b1; tick(2);
        claim_chk(0, 3, "R10 first claim");
        wr(a_clm(0), 7);
        src[2] = 1'b0; tick(1); src[2] = 1'b1; tick(2);
        claim_chk(0, 0, "R10 out of range complete ignored");
        wr(a_en(0), 32'h36);
        wr(a_clm(0), 3);
        wr(a_en(0), 32'h3E);
        claim_chk(0, 0, "R10 disabled complete ignored");
        wr(a_clm(0), 3);
        claim_chk(0, 3, "R10 valid complete");
    endtask

    task automatic t_fall();
        clean();
        wr(a_en(0), 32'h3E);
        src[0] = 1'b1; tick(2);
        src[0] = 1'b0; tick(2);
        chk("R6 fall clears output", 32'(meip), 0);
        claim_chk(0, 0, "R6 fall clears pending");
    endtask

    task automatic t_contexts();
        clean();
        wr(a_en(1), 32'h20);
        wr(a_en(2), 32'h20);
        src[4] = 1'b1; tick(2);
        chk("R11 meip map", 32'(meip), 2);
        chk("R11 seip map", 32'(seip), 1);
        claim_chk(1, 5, "R9 claim ctx1");
        claim_chk(2, 0, "R9 pending cleared for ctx2");
        tick(1);
        chk("R11 meip cleared", 32'(meip), 0);
        chk("R11 seip cleared", 32'(seip), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_access();
        t_enable();
        t_masking();
        t_arbitrate();
        t_threshold();
        t_complete();
        t_fall();
        t_contexts();
        finish_run();
    end
endmodule